// File: doc/BRIEF.md
# Serial EEPROM Command Host

This block is the master side of a three-wire serial EEPROM link of the Microwire kind. Its command port takes a 2-bit opcode, an address, write data and a width flag that selects 16-bit or 8-bit word mode. A one-cycle start pulse launches a transaction. The block then drives chip select, a divided serial clock and the serial data line toward the memory, and samples the memory's data output.

Each frame is a start bit of one, the opcode and the address, and then either write data or a read phase. For a read, the host clocks in one extra leading bit, drops it, and returns the word that follows. For the commands that program the array, the host lowers chip select for a minimum time once the frame is sent. It then raises chip select again and watches the memory's output until it goes high, meaning ready. A timeout bounds that wait. The command side sees a busy level, a one-cycle done pulse and an error flag.

Top module: `serial_eeprom_host`

## Requirements
- R1: A frame drives a one, then the two opcode bits, then the address, all most significant bit first. The serial clock rests low and is low whenever chip select is low. The data line changes only while the serial clock is low, and it is low while chip select is low.
- R2: Word mode (cmd_wide=1) sends 7 address bits, cmd_addr[6:0], and uses 16-bit data. Byte mode (cmd_wide=0) sends 8 address bits and uses 8-bit data, cmd_wdata[7:0].
- R3: Opcode 10 reads. After the address, the host clocks 1+width bits and samples each one on the rising serial clock edge. It discards the first and returns the rest MSB first on cmd_rdata, zero-extended in byte mode, valid while cmd_done is high. The data line stays low during this phase.
- R4: Opcode 01 (write) and opcode 00 with address top bits 01 (write-all) send the data word right after the address. In word mode the top bits are cmd_addr[6:5]; in byte mode they are cmd_addr[7:6].
- R5: Opcode 01, opcode 11, and opcode 00 with top bits 01 or 10 are programming commands. After such a frame, chip select stays low for at least DESEL_CYC clocks and then goes high. cmd_done follows only once mem_miso is seen high.
- R6: Opcode 00 with top bits 11 (write enable) or 00 (write disable) sends only the 10- or 11-bit header. Chip select then drops, cmd_done pulses and no ready wait follows.
- R7: Each high phase of the serial clock lasts exactly HALF = ceil(CLK_HZ / (2*SCK_HZ)) clocks, so the serial clock never exceeds SCK_HZ.
- R8: If mem_miso stays low for POLL_LIMIT clocks of the ready wait, the host drops chip select and pulses cmd_done with cmd_err high. cmd_err stays high until the next accepted start.
- R9: A start is taken only while cmd_busy is low. cmd_busy rises the clock after an accepted start and falls with cmd_done. cmd_done lasts one clock. A start during a transaction has no effect on the frame or on the done count.
- R10: After reset, mem_cs, mem_sck, mem_mosi, cmd_busy, cmd_done and cmd_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Launch pulse, honoured while idle |
| cmd_op | input | 2 | Opcode |
| cmd_addr | input | 8 | Address; top bits select extended opcode-00 commands |
| cmd_wdata | input | 16 | Write data (low byte in byte mode) |
| cmd_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cmd_rdata | output | 16 | Read result |
| cmd_done | output | 1 | One-clock completion pulse |
| cmd_busy | output | 1 | Transaction in progress |
| cmd_err | output | 1 | Ready wait timed out |
| mem_cs | output | 1 | Chip select to the memory, active high |
| mem_sck | output | 1 | Serial clock to the memory |
| mem_mosi | output | 1 | Serial data to the memory |
| mem_miso | input | 1 | Serial data and ready status from the memory |

## Verification
The assertions take mem_miso to be synchronous to clk, since the host samples it without a synchronizer. They also take DESEL_CYC and HALF to be at least one. The bench's memory model meets this. It changes its output only in response to serial-clock rising edges or on the falling system-clock edge, so every sample the host takes is settled. Command fields are held steady from the start pulse onward, except in the test that deliberately changes them mid-transaction.

// File: rtl/serial_eeprom_host.sv
module serial_eeprom_host #(
  parameter int CLK_HZ     = 200_000_000,
  parameter int SCK_HZ     = 2_000_000,
  parameter int DESEL_CYC  = 40,
  parameter int POLL_LIMIT = 1_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic        cmd_wide,
  output logic [15:0] cmd_rdata,
  output logic        cmd_done,
  output logic        cmd_busy,
  output logic        cmd_err,
  output logic        mem_cs,
  output logic        mem_sck,
  output logic        mem_mosi,
  input  logic        mem_miso
);
  localparam int HALF_RAW = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int DVW      = $clog2(HALF + 1);
  localparam int TMAX     = (POLL_LIMIT > DESEL_CYC) ? POLL_LIMIT : DESEL_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int TXW      = 27;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_DESEL, S_POLL} st_t;
  st_t st;

  logic [TXW-1:0] tx;
  logic [15:0]    rx;
  logic [5:0]     bitn, nbits;
  logic [DVW-1:0] div;
  logic [TW-1:0]  tmr;
  logic           is_rd, is_prog, wide_q;

  logic [1:0] top2;
  logic       c_rd, c_data, c_prog;
  logic [5:0] c_nbits;
  logic [TXW-1:0] c_tx;
  logic       tick, last_bit;

  assign top2   = cmd_wide ? cmd_addr[6:5] : cmd_addr[7:6];
  assign c_rd   = (cmd_op == 2'b10);
  assign c_data = (cmd_op == 2'b01) || (cmd_op == 2'b00 && top2 == 2'b01);
  assign c_prog = (cmd_op == 2'b01) || (cmd_op == 2'b11) ||
                  (cmd_op == 2'b00 && (top2 == 2'b01 || top2 == 2'b10));

  always_comb begin
    c_nbits = cmd_wide ? 6'd10 : 6'd11;
    if (c_data) c_nbits = c_nbits + (cmd_wide ? 6'd16 : 6'd8);
    if (c_rd)   c_nbits = c_nbits + (cmd_wide ? 6'd17 : 6'd9);
    if (cmd_wide)
      c_tx = {1'b1, cmd_op, cmd_addr[6:0], (c_data ? cmd_wdata : 16'h0000), 1'b0};
    else
      c_tx = {1'b1, cmd_op, cmd_addr, (c_data ? cmd_wdata[7:0] : 8'h00), 8'h00};
  end

  assign tick     = (div == DVW'(HALF - 1));
  assign last_bit = (bitn == nbits - 6'd1);
  assign cmd_busy = (st != S_IDLE);
  assign mem_mosi = mem_cs && (st == S_SHIFT) && tx[TXW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  tx <= '0;  rx <= '0;  bitn <= '0;  nbits <= '0;
      div <= '0;  tmr <= '0;  is_rd <= 1'b0;  is_prog <= 1'b0;  wide_q <= 1'b0;
      mem_cs <= 1'b0;  mem_sck <= 1'b0;
      cmd_done <= 1'b0;  cmd_err <= 1'b0;  cmd_rdata <= '0;
    end else begin
      cmd_done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_start) begin
          st <= S_SHIFT;  mem_cs <= 1'b1;  mem_sck <= 1'b0;
          div <= '0;  bitn <= '0;  nbits <= c_nbits;  tx <= c_tx;
          is_rd <= c_rd;  is_prog <= c_prog;  wide_q <= cmd_wide;
          cmd_err <= 1'b0;
        end
        S_SHIFT: begin
          div <= tick ? '0 : div + DVW'(1);
          if (tick) begin
            if (!mem_sck) begin
              mem_sck <= 1'b1;
              rx <= {rx[14:0], mem_miso};
            end else begin
              mem_sck <= 1'b0;
              tx <= {tx[TXW-2:0], 1'b0};
              if (last_bit) begin
                mem_cs <= 1'b0;
                tmr <= '0;
                if (is_prog) st <= S_DESEL;
                else begin
                  st <= S_IDLE;
                  cmd_done <= 1'b1;
                  if (is_rd) cmd_rdata <= wide_q ? rx : {8'h00, rx[7:0]};
                end
              end else begin
                bitn <= bitn + 6'd1;
              end
            end
          end
        end
        S_DESEL: begin
          if (tmr == TW'(DESEL_CYC - 1)) begin
            mem_cs <= 1'b1;  tmr <= '0;  st <= S_POLL;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        S_POLL: begin
          if (mem_miso) begin
            mem_cs <= 1'b0;  cmd_done <= 1'b1;  st <= S_IDLE;
          end else if (tmr == TW'(POLL_LIMIT - 1)) begin
            mem_cs <= 1'b0;  cmd_done <= 1'b1;  cmd_err <= 1'b1;  st <= S_IDLE;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_eeprom_host_props #(
  parameter int CLK_HZ    = 200_000_000,
  parameter int SCK_HZ    = 2_000_000,
  parameter int DESEL_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic cmd_done,
  input logic cmd_busy,
  input logic cmd_err,
  input logic mem_cs,
  input logic mem_sck,
  input logic mem_mosi
);
  localparam int HALF_RAW = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  int hi_cnt, lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= 0;  lo_cnt <= 0;
    end else begin
      hi_cnt <= mem_sck ? hi_cnt + 1 : 0;
      lo_cnt <= mem_cs ? 0 : ((lo_cnt < DESEL_CYC) ? lo_cnt + 1 : lo_cnt);
    end
  end

  AST_SCK_GATED:    assert property (@(posedge clk) disable iff (!rst_n) !mem_cs |-> !mem_sck);                      // R1
  AST_MOSI_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !mem_cs |-> !mem_mosi);                     // R1
  AST_MOSI_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) (mem_sck && $past(mem_sck)) |-> $stable(mem_mosi)); // R1
  AST_DESEL_MIN:    assert property (@(posedge clk) disable iff (!rst_n) ($rose(mem_cs) && $past(cmd_busy)) |-> lo_cnt >= DESEL_CYC); // R5
  AST_SCK_HIGH:     assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_sck) |-> hi_cnt == HALF);       // R7
  AST_ERR_AT_DONE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(cmd_err) |-> cmd_done);             // R8
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) cmd_done |=> !cmd_done);                  // R9
  AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) cmd_done |=> !cmd_busy);                  // R9
  AST_START_TAKEN:  assert property (@(posedge clk) disable iff (!rst_n) (cmd_start && !cmd_busy) |=> cmd_busy);   // R9
endmodule

bind serial_eeprom_host serial_eeprom_host_props #(
  .CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .DESEL_CYC(DESEL_CYC)
) u_props (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_done(cmd_done),
  .cmd_busy(cmd_busy), .cmd_err(cmd_err), .mem_cs(mem_cs),
  .mem_sck(mem_sck), .mem_mosi(mem_mosi)
);

// File: tb/tb_serial_eeprom_host.sv
module tb_serial_eeprom_host;
  localparam int CLK_HZ = 200_000_000, SCK_HZ = 2_000_000;
  localparam int DESEL = 40, PLIM = 2000;
  localparam int HALF = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_wide = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_addr = 8'h00;
  logic [15:0] cmd_wdata = 16'h0000;
  logic [15:0] cmd_rdata;
  logic cmd_done, cmd_busy, cmd_err, mem_cs, mem_sck, mem_mosi, mem_miso;

  always #2.5 clk = ~clk;

  serial_eeprom_host #(.CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .DESEL_CYC(DESEL), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_wide(cmd_wide), .cmd_rdata(cmd_rdata), .cmd_done(cmd_done),
    .cmd_busy(cmd_busy), .cmd_err(cmd_err), .mem_cs(mem_cs), .mem_sck(mem_sck),
    .mem_mosi(mem_mosi), .mem_miso(mem_miso));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // memory model
  logic [63:0] cap = '0;
  int rcount = 0, base = 0, mhdr = 10, mdw = 16, busy_cfg = 0, busy_left = 0;
  logic [15:0] mword = '0;
  logic poll_mode = 1'b0, rd_bit, pcs = 1'b0;

  always @(posedge mem_sck) if (mem_cs) begin
    cap = {cap[62:0], mem_mosi};
    rcount = rcount + 1;
  end

  always_comb begin
    int k;
    k = rcount - base - (mhdr + 1);
    rd_bit = (k >= 0 && k < mdw) ? mword[mdw - 1 - k] : 1'b0;
  end
  assign mem_miso = poll_mode ? (busy_left == 0) : rd_bit;

  // monitors
  int rises = 0, last_gap = 0, lowrun = 0, hi_run = 0, bad_hi = 0, dones = 0, cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (pcs && !mem_cs) busy_left = busy_cfg;
    else if (busy_left > 0) busy_left = busy_left - 1;
    if (mem_cs && !pcs) begin rises++; last_gap = lowrun; end
    if (mem_cs) lowrun = 0; else if (cmd_busy) lowrun++;
    if (mem_sck) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != HALF) bad_hi++;
      hi_run = 0;
    end
    if (cmd_done) dones++;
    pcs = mem_cs;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog R9 actual %0d expected %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // stimulus table: {wide, op, addr, wdata, mem, busy}
  localparam int VW = 55;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'b10, 8'h55, 16'h0000, 16'hA5C3, 12'd0},    // wide read
    {1'b0, 2'b10, 8'hC6, 16'h0000, 16'h0096, 12'd0},    // byte read
    {1'b1, 2'b00, 8'h60, 16'h0000, 16'h0000, 12'd0},    // enable
    {1'b1, 2'b01, 8'h2B, 16'h3C5A, 16'h0000, 12'd300},  // wide write
    {1'b0, 2'b01, 8'h81, 16'h00E7, 16'h0000, 12'd150},  // byte write
    {1'b0, 2'b11, 8'h12, 16'h0000, 16'h0000, 12'd200},  // erase
    {1'b0, 2'b00, 8'h40, 16'h005A, 16'h0000, 12'd100},  // write-all
    {1'b1, 2'b00, 8'h00, 16'h0000, 16'h0000, 12'd0}     // disable
  };

  task automatic run(input bit w, input logic [1:0] op, input logic [7:0] a,
                     input logic [15:0] wd, input logic [15:0] mem, input int bsy,
                     input bit exp_err, input bit poke);
    logic [1:0] t2;
    bit rd, dat, prg;
    int hdr, dw, nb, r0, b0, d0, n;
    logic [63:0] e;
    t2  = w ? a[6:5] : a[7:6];
    rd  = (op == 2'b10);
    dat = (op == 2'b01) || (op == 2'b00 && t2 == 2'b01);
    prg = (op == 2'b01) || (op == 2'b11) || (op == 2'b00 && (t2 == 2'b01 || t2 == 2'b10));
    hdr = w ? 10 : 11;  dw = w ? 16 : 8;
    e = 64'd1;
    e = (e << 2) | 64'(op);
    e = (e << (w ? 7 : 8)) | 64'(w ? {1'b0, a[6:0]} : a);
    if (dat) e = (e << dw) | 64'(w ? wd : {8'h00, wd[7:0]});
    if (rd) e = e << (dw + 1);
    nb = hdr + (dat ? dw : 0) + (rd ? dw + 1 : 0);
    base = rcount;  mhdr = hdr;  mdw = dw;  mword = mem;
    poll_mode = prg;  busy_cfg = bsy;
    r0 = rises;  b0 = bad_hi;  d0 = dones;
    cmd_wide = w;  cmd_op = op;  cmd_addr = a;  cmd_wdata = wd;
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    chk(cmd_busy == 1'b1, "R9 busy after start", cmd_busy, 1);
    n = 0;
    while (!cmd_done && n < 20000) begin
      if (poke && n == 200) begin
        cmd_op = 2'b10;  cmd_addr = ~a;  cmd_wide = ~w;  cmd_start = 1'b1;
      end else cmd_start = 1'b0;
      @(negedge clk) n++;
    end
    cmd_start = 1'b0;
    chk(cmd_done == 1'b1, "R9 done seen", cmd_done, 1);
    chk(rcount - base == nb, "R2 frame length", rcount - base, nb);
    chk((cap & ((64'd1 << nb) - 1)) == e, dat ? "R4 frame bits" : "R1 frame bits",
        cap & ((64'd1 << nb) - 1), e);
    chk(cmd_err == exp_err, "R8 error flag", cmd_err, exp_err);
    if (rd) chk(cmd_rdata == (w ? mem : {8'h00, mem[7:0]}), "R3 read data", cmd_rdata,
                w ? mem : {8'h00, mem[7:0]});
    if (prg) begin
      chk(rises - r0 == 2, "R5 reselect for polling", rises - r0, 2);
      chk(last_gap >= DESEL, "R5 deselect width", last_gap, DESEL);
      if (!exp_err) chk(busy_left == 0, "R5 done only when ready", busy_left, 0);
    end else begin
      chk(rises - r0 == 1, "R6 no polling phase", rises - r0, 1);
    end
    chk(bad_hi == b0, "R7 clock high width", bad_hi - b0, 0);
    repeat (3) @(negedge clk);
    chk(dones - d0 == 1, "R9 single done pulse", dones - d0, 1);
    chk(!cmd_busy && !mem_cs, "R9 idle after done", {cmd_busy, mem_cs}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({mem_cs, mem_sck, mem_mosi, cmd_busy, cmd_done, cmd_err} == 6'b0, "R10 reset state",
        {mem_cs, mem_sck, mem_mosi, cmd_busy, cmd_done, cmd_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({mem_cs, mem_sck, cmd_busy} == 3'b0, "R10 idle after reset", {mem_cs, mem_sck, cmd_busy}, 0);

    for (int i = 0; i < NV; i++)
      run(VEC[i][54], VEC[i][53:52], VEC[i][51:44], VEC[i][43:28], VEC[i][27:12],
          int'(VEC[i][11:0]), 1'b0, 1'b0);

    // R8: memory never ready -> timeout, then error clears on next start
    run(1'b1, 2'b01, 8'h07, 16'hBEEF, 16'h0000, 4000, 1'b1, 1'b0);
    run(1'b1, 2'b00, 8'h60, 16'h0000, 16'h0000, 0, 1'b0, 1'b0);
    // R9: start during an active read is ignored
    run(1'b1, 2'b10, 8'h3A, 16'h0000, 16'h1E2D, 0, 1'b0, 1'b1);
    // R3: read of all ones and byte mode top address
    run(1'b0, 2'b10, 8'hFF, 16'h0000, 16'h00FF, 0, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule